// File: doc/BRIEF.md
# Command Mailbox Register Target

This block is a 32-bit memory-mapped register target that lets a host hand commands to a local responder. The host loads up to seven argument words, then writes a nonzero request word that names a target type, a target instance, a command class and an opcode. That write launches the command: the block pulses a start strobe toward the responder and presents the decoded request fields and the argument words on its responder port.

While the command runs, the request register keeps its nonzero value, so the host reads it as a busy indication and cannot overwrite it. When the responder signals completion, the block captures a short result, two error codes and three result words. In that same clock edge it zeroes the request register and raises a ready flag. The host reads the results and writes the ready flag back to zero. Until it does, the block refuses any new command.

Reads are combinational, from a single address port. Writes take effect on the clock edge at which the write strobe is sampled.

Top module: `cmd_mailbox_regs`

## Requirements
- R1: Argument word i (i = 0..6) is read/write at byte offset 0x438 - 4*i, so argument 0 is at 0x438 and argument 6 at 0x420. All argument words reset to zero.
- R2: The result status word reads at 0x45C. Result word j (j = 0..2) reads at 0x458 - 4*j. Both are zero after reset.
- R3: A write of a nonzero value to the request word at 0x43C, made while the block is idle with the ready flag clear, launches a command. `cmd_start` is high for exactly the one cycle after the write edge. In that cycle `cmd_tgt_type` = request[31:29], `cmd_tgt_inst` = request[28:24], `cmd_kind` = request[23:16], `cmd_opcode` = request[15:0], and `cmd_params` holds argument i in bits [32*i+31:32*i].
- R4: While a command runs, the request word reads back the launching value. Writes to the request word and to the argument words are ignored.
- R5: On the clock edge where `rsp_done` is sampled high while a command runs, the request word becomes zero, the ready flag becomes 1, and the result fields and words are captured. `rsp_done` while idle changes nothing.
- R6: The status word is packed as: bit 0 = ready flag, bits [4:1] = general error code, bits [7:5] = command error code, bits [15:8] = zero, bits [31:16] = short result.
- R7: A write to the status word with bit 0 = 0 clears the ready flag. A write with bit 0 = 1 leaves it set. Writes never alter the other status bits.
- R8: A request write made while the ready flag is set is ignored and launches nothing.
- R9: An argument word that is not written before a command keeps its previous value and is presented unchanged to the responder.
- R10: Reads of any offset other than the request, argument, status and result words return zero. Result words and result fields stay unchanged until the next accepted completion.
- R11: Writing zero to the request word while idle launches nothing, and the request word stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 12 | Host write byte offset |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 12 | Host read byte offset |
| rd_data | output | 32 | Host read data (combinational) |
| cmd_start | output | 1 | One-cycle launch strobe to the responder |
| cmd_tgt_type | output | 3 | Target type field of the running request |
| cmd_tgt_inst | output | 5 | Target instance field of the running request |
| cmd_kind | output | 8 | Command class field of the running request |
| cmd_opcode | output | 16 | Opcode field of the running request |
| cmd_params | output | 224 | Seven argument words, argument i in bits [32*i+31:32*i] |
| rsp_done | input | 1 | Responder completion strobe |
| rsp_short | input | 16 | Short result value |
| rsp_err_code | input | 3 | Command error code |
| rsp_gen_err | input | 4 | General error code |
| rsp_data | input | 96 | Three result words, word j in bits [32*j+31:32*j] |

## Verification
The hardest windows to reach are the short ones around a running command. Host writes that land while the request is busy must be dropped, and a completion can arrive in the very cycle after launch, which leaves almost no gap between start and finish. The bench's stub responder has a latency that can be changed per command. A long setting holds the block busy long enough to fire ignored argument and request writes into the window. A zero setting makes the completion coincide with the first cycle the start strobe is visible. Stray completions while idle, and request writes while the ready flag is still set, are driven directly from the host side.

// File: rtl/cmdmbx_pkg.sv
package cmdmbx_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] REQ_OFF    = 12'h43C;
  localparam logic [ADDR_W-1:0] ARG0_OFF   = 12'h438;
  localparam logic [ADDR_W-1:0] STAT_OFF   = 12'h45C;
  localparam logic [ADDR_W-1:0] RWORD0_OFF = 12'h458;

  typedef struct packed {
    logic [2:0]  tgt_type;
    logic [4:0]  tgt_inst;
    logic [7:0]  kind;
    logic [15:0] opcode;
  } req_word_t;

  // argument words descend from ARG0_OFF in word steps
  function automatic logic [ADDR_W-1:0] arg_off(input int idx);
    return ARG0_OFF - ADDR_W'(4 * idx);
  endfunction

  // result words descend from RWORD0_OFF in word steps
  function automatic logic [ADDR_W-1:0] rword_off(input int idx);
    return RWORD0_OFF - ADDR_W'(4 * idx);
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic       ready,
                                                    input logic [3:0] gen_err,
                                                    input logic [2:0] cmd_err,
                                                    input logic [15:0] short_val);
    return {short_val, 8'h00, cmd_err, gen_err, ready};
  endfunction
endpackage

// File: rtl/cmdmbx_arg_bank.sv
module cmdmbx_arg_bank
  import cmdmbx_pkg::*;
#(
  parameter int NUM_ARGS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       busy,
  output logic [NUM_ARGS*WORD_W-1:0] args
);
  logic [WORD_W-1:0] arg_q [NUM_ARGS];

  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
    logic arg_hit;
    assign arg_hit = wr_en && !busy && (wr_addr == arg_off(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       arg_q[g] <= '0;
      else if (arg_hit) arg_q[g] <= wr_data;
    end

    assign args[g*WORD_W +: WORD_W] = arg_q[g];
  end
endmodule

// File: rtl/cmdmbx_ctrl.sv
module cmdmbx_ctrl
  import cmdmbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              stat_wr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rsp_done,
  output logic [WORD_W-1:0] req_q,
  output logic              ready_q,
  output logic              busy,
  output logic              cmd_start,
  output logic              req_accept,
  output logic              done_accept,
  output logic              ready_clear
);
  assign busy        = |req_q;
  assign req_accept  = req_wr && !busy && !ready_q && (wr_data != '0);
  assign done_accept = rsp_done && busy;
  assign ready_clear = stat_wr && !wr_data[0] && ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= '0;
      ready_q   <= 1'b0;
      cmd_start <= 1'b0;
    end else begin
      cmd_start <= req_accept;
      if (req_accept)       req_q <= wr_data;
      else if (done_accept) req_q <= '0;
      if (done_accept)      ready_q <= 1'b1;
      else if (ready_clear) ready_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdmbx_result.sv
module cmdmbx_result
  import cmdmbx_pkg::*;
#(
  parameter int NUM_RWORDS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         done_accept,
  input  logic                         ready_q,
  input  logic [15:0]                  rsp_short,
  input  logic [2:0]                   rsp_err_code,
  input  logic [3:0]                   rsp_gen_err,
  input  logic [NUM_RWORDS*WORD_W-1:0] rsp_data,
  output logic [NUM_RWORDS*WORD_W-1:0] rword_q,
  output logic [WORD_W-1:0]            status_word
);
  logic [15:0] short_q;
  logic [2:0]  cerr_q;
  logic [3:0]  gerr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      short_q <= '0;
      cerr_q  <= '0;
      gerr_q  <= '0;
      rword_q <= '0;
    end else if (done_accept) begin
      short_q <= rsp_short;
      cerr_q  <= rsp_err_code;
      gerr_q  <= rsp_gen_err;
      rword_q <= rsp_data;
    end
  end

  assign status_word = pack_status(ready_q, gerr_q, cerr_q, short_q);
endmodule

// File: rtl/cmdmbx_rdmux.sv
module cmdmbx_rdmux
  import cmdmbx_pkg::*;
#(
  parameter int NUM_ARGS   = 7,
  parameter int NUM_RWORDS = 3
) (
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [WORD_W-1:0]            req_q,
  input  logic [WORD_W-1:0]            status_word,
  input  logic [NUM_ARGS*WORD_W-1:0]   args,
  input  logic [NUM_RWORDS*WORD_W-1:0] rwords,
  output logic [WORD_W-1:0]            rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == REQ_OFF)  rd_data = req_q;
    if (rd_addr == STAT_OFF) rd_data = status_word;
    for (int i = 0; i < NUM_ARGS; i++)
      if (rd_addr == arg_off(i)) rd_data = args[i*WORD_W +: WORD_W];
    for (int j = 0; j < NUM_RWORDS; j++)
      if (rd_addr == rword_off(j)) rd_data = rwords[j*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/cmd_mailbox_regs.sv
module cmd_mailbox_regs
  import cmdmbx_pkg::*;
#(
  parameter int NUM_ARGS   = 7,
  parameter int NUM_RWORDS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [11:0]                  wr_addr,
  input  logic [31:0]                  wr_data,
  input  logic [11:0]                  rd_addr,
  output logic [31:0]                  rd_data,
  output logic                         cmd_start,
  output logic [2:0]                   cmd_tgt_type,
  output logic [4:0]                   cmd_tgt_inst,
  output logic [7:0]                   cmd_kind,
  output logic [15:0]                  cmd_opcode,
  output logic [NUM_ARGS*32-1:0]       cmd_params,
  input  logic                         rsp_done,
  input  logic [15:0]                  rsp_short,
  input  logic [2:0]                   rsp_err_code,
  input  logic [3:0]                   rsp_gen_err,
  input  logic [NUM_RWORDS*32-1:0]     rsp_data
);
  localparam int ARG_BITS   = NUM_ARGS * WORD_W;
  localparam int RWORD_BITS = NUM_RWORDS * WORD_W;

  logic              req_wr, stat_wr;
  logic [WORD_W-1:0] req_q;
  logic              ready_q, busy;
  logic              req_accept, done_accept, ready_clear;
  logic [WORD_W-1:0] status_word;
  logic [RWORD_BITS-1:0] rword_q;
  logic [ARG_BITS-1:0]   args;
  req_word_t         req_fields;

  assign req_wr  = wr_en && (wr_addr == REQ_OFF);
  assign stat_wr = wr_en && (wr_addr == STAT_OFF);

  cmdmbx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_wr      (req_wr),
    .stat_wr     (stat_wr),
    .wr_data     (wr_data),
    .rsp_done    (rsp_done),
    .req_q       (req_q),
    .ready_q     (ready_q),
    .busy        (busy),
    .cmd_start   (cmd_start),
    .req_accept  (req_accept),
    .done_accept (done_accept),
    .ready_clear (ready_clear)
  );

  cmdmbx_arg_bank #(.NUM_ARGS(NUM_ARGS)) u_args (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .args    (args)
  );

  cmdmbx_result #(.NUM_RWORDS(NUM_RWORDS)) u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_accept  (done_accept),
    .ready_q      (ready_q),
    .rsp_short    (rsp_short),
    .rsp_err_code (rsp_err_code),
    .rsp_gen_err  (rsp_gen_err),
    .rsp_data     (rsp_data),
    .rword_q      (rword_q),
    .status_word  (status_word)
  );

  cmdmbx_rdmux #(.NUM_ARGS(NUM_ARGS), .NUM_RWORDS(NUM_RWORDS)) u_rdmux (
    .rd_addr     (rd_addr),
    .req_q       (req_q),
    .status_word (status_word),
    .args        (args),
    .rwords      (rword_q),
    .rd_data     (rd_data)
  );

  assign req_fields   = req_word_t'(req_q);
  assign cmd_tgt_type = req_fields.tgt_type;
  assign cmd_tgt_inst = req_fields.tgt_inst;
  assign cmd_kind     = req_fields.kind;
  assign cmd_opcode   = req_fields.opcode;
  assign cmd_params   = args;
endmodule

// File: rtl/cmdmbx_chk.sv
module cmdmbx_chk
  import cmdmbx_pkg::*;
#(
  parameter int NUM_ARGS   = 7,
  parameter int NUM_RWORDS = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic [WORD_W-1:0]            wr_data,
  input logic                         rsp_done,
  input logic                         cmd_start,
  input logic [NUM_ARGS*WORD_W-1:0]   cmd_params,
  input logic                         busy,
  input logic                         ready_q,
  input logic                         done_accept,
  input logic [NUM_RWORDS*WORD_W-1:0] rword_q
);
  a_r3_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy);

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_done) |=> busy);

  a_r4_args_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_params));

  a_r5_done_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    done_accept |=> (!busy && ready_q));

  a_r7_ready_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !(wr_en && wr_addr == STAT_OFF && !wr_data[0])) |=> ready_q);

  a_r8_no_start_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !cmd_start);

  a_r10_rwords_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_accept |=> $stable(rword_q));
endmodule

bind cmd_mailbox_regs cmdmbx_chk #(.NUM_ARGS(NUM_ARGS), .NUM_RWORDS(NUM_RWORDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rsp_done    (rsp_done),
  .cmd_start   (cmd_start),
  .cmd_params  (cmd_params),
  .busy        (busy),
  .ready_q     (ready_q),
  .done_accept (done_accept),
  .rword_q     (rword_q)
);

// File: tb/tb_cmd_mailbox_regs.sv
module tb_cmd_mailbox_regs;
  localparam int NA = 7;
  localparam int NR = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [11:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic cmd_start;
  logic [2:0] cmd_tgt_type;
  logic [4:0] cmd_tgt_inst;
  logic [7:0] cmd_kind;
  logic [15:0] cmd_opcode;
  logic [NA*32-1:0] cmd_params;
  logic rsp_done;
  logic [15:0] rsp_short;
  logic [2:0] rsp_err_code;
  logic [3:0] rsp_gen_err;
  logic [NR*32-1:0] rsp_data;

  always #2 clk = ~clk;

  cmd_mailbox_regs dut (.*);

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int tb_lat = 0;

  logic [31:0] arg_m [NA];          // bench mirror of the argument words
  logic [31:0] exp_q [$];           // scoreboard: request word then arguments

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [11:0] a_off(input int i);
    return 12'h438 - 12'(4 * i);
  endfunction

  function automatic logic [11:0] r_off(input int j);
    return 12'h458 - 12'(4 * j);
  endfunction

  // driver: writes the request and pushes what the monitor must see
  task automatic issue(input logic [31:0] req, input bit expect_start);
    if (expect_start) begin
      exp_q.push_back(req);
      for (int i = 0; i < NA; i++) exp_q.push_back(arg_m[i]);
    end
    wr(12'h43C, req);
  endtask

  // monitor: pops expected launch content when the start strobe appears (R3)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cmd_start === 1'b1) begin
      starts++;
      if (exp_q.size() < 1 + NA) begin
        checks++; errors++;
        $display("FAIL R3 unexpected start actual=1 expected=0");
      end else begin
        logic [31:0] r;
        r = exp_q.pop_front();
        check("R3 type",   {29'd0, cmd_tgt_type}, {29'd0, r[31:29]});
        check("R3 inst",   {27'd0, cmd_tgt_inst}, {27'd0, r[28:24]});
        check("R3 kind",   {24'd0, cmd_kind},     {24'd0, r[23:16]});
        check("R3 opcode", {16'd0, cmd_opcode},   {16'd0, r[15:0]});
        for (int i = 0; i < NA; i++) begin
          logic [31:0] p;
          p = exp_q.pop_front();
          check("R3 R9 arg", cmd_params[i*32 +: 32], p);
        end
      end
    end
  end

  // stub responder: answers each launch after tb_lat cycles
  logic [31:0] stub_req;
  logic [NA*32-1:0] stub_args;
  initial begin
    rsp_done = 1'b0; rsp_short = '0; rsp_err_code = '0; rsp_gen_err = '0; rsp_data = '0;
    forever begin
      @(negedge clk);
      if (cmd_start === 1'b1) begin
        stub_req  = {cmd_tgt_type, cmd_tgt_inst, cmd_kind, cmd_opcode};
        stub_args = cmd_params;
        repeat (tb_lat) @(negedge clk);
        rsp_done     = 1'b1;
        rsp_short    = stub_req[15:0] ^ stub_args[15:0];
        rsp_err_code = stub_req[18:16];
        rsp_gen_err  = stub_req[27:24];
        for (int j = 0; j < NR; j++) rsp_data[j*32 +: 32] = stub_args[j*32 +: 32] + 32'(j + 1);
        @(negedge clk);
        rsp_done = 1'b0;
      end
    end
  end

  function automatic logic [31:0] exp_status(input logic [31:0] req, input logic rdy);
    logic [15:0] s;
    s = req[15:0] ^ arg_m[0][15:0];
    return {s, 8'h00, req[18:16], req[27:24], rdy};
  endfunction

  task automatic wait_ready();
    logic [31:0] v;
    for (int k = 0; k < 200; k++) begin
      rd(12'h45C, v);
      if (v[0]) break;
    end
  endtask

  task automatic check_results(input logic [31:0] req, input string tag);
    logic [31:0] v;
    rd(12'h43C, v);  check({tag, " R5 request zero"}, v, 32'h0);
    rd(12'h45C, v);  check({tag, " R6 status"}, v, exp_status(req, 1'b1));
    for (int j = 0; j < NR; j++) begin
      rd(r_off(j), v);
      check({tag, " R2 result word"}, v, arg_m[j] + 32'(j + 1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] req_a, req_b;
    int s0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int i = 0; i < NA; i++) arg_m[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R1 R2 R3)
    rd(12'h43C, v); check("R3 reset request", v, 0);
    rd(12'h45C, v); check("R2 reset status", v, 0);
    rd(12'h420, v); check("R1 reset arg6", v, 0);
    rd(12'h450, v); check("R2 reset result2", v, 0);

    // unused offsets read zero (R10)
    rd(12'h440, v); check("R10 unused 0x440", v, 0);
    rd(12'h44C, v); check("R10 unused 0x44C", v, 0);
    rd(12'h41C, v); check("R10 unused 0x41C", v, 0);
    rd(12'h000, v); check("R10 unused 0x000", v, 0);

    // command A: all arguments, long latency
    for (int i = 0; i < NA; i++) begin
      arg_m[i] = 32'hA0000000 | (32'(i) << 8) | 32'(3 * i + 1);
      wr(a_off(i), arg_m[i]);
    end
    rd(12'h42C, v); check("R1 arg3 readback", v, arg_m[3]);
    tb_lat = 14;
    req_a = {3'd5, 5'd9, 8'h21, 16'h1234};
    issue(req_a, 1'b1);
    rd(12'h43C, v); check("R4 busy readback", v, req_a);
    wr(12'h438, 32'hDEADBEEF);
    rd(12'h438, v); check("R4 arg write while busy", v, arg_m[0]);
    wr(12'h43C, 32'h0F0F0F0F);
    rd(12'h43C, v); check("R4 request write while busy", v, req_a);
    wait_ready();
    check_results(req_a, "cmdA");

    // ready set: status write of 1 keeps it, request ignored (R7 R8)
    wr(12'h45C, 32'hFFFFFFFF);
    rd(12'h45C, v); check("R7 write one keeps ready", v, exp_status(req_a, 1'b1));
    s0 = starts;
    issue(32'h2200_0001, 1'b0);
    rd(12'h43C, v); check("R8 request while ready", v, 0);
    repeat (3) @(negedge clk);
    check("R8 no launch while ready", 32'(starts), 32'(s0));
    wr(12'h45C, 32'hFFFF0000);
    rd(12'h45C, v); check("R7 write zero clears ready", v, exp_status(req_a, 1'b0));

    // zero request starts nothing (R11)
    issue(32'h0, 1'b0);
    rd(12'h43C, v); check("R11 zero request", v, 0);
    repeat (3) @(negedge clk);
    check("R11 no launch", 32'(starts), 32'(s0));

    // command B: only argument 1 rewritten, zero latency (R9)
    arg_m[1] = 32'h5555AAAA;
    wr(a_off(1), arg_m[1]);
    tb_lat = 0;
    req_b = {3'd2, 5'd30, 8'h07, 16'hFEDC};
    issue(req_b, 1'b1);
    wait_ready();
    check_results(req_b, "cmdB");
    rd(12'h438, v); check("R9 arg0 kept", v, arg_m[0]);
    wr(12'h45C, 32'h0);

    // stray completion while idle (R5 R10)
    @(negedge clk);
    rsp_done = 1'b1; rsp_short = 16'h7777; rsp_err_code = 3'd7; rsp_gen_err = 4'hF;
    rsp_data = {NR{32'hCAFEF00D}};
    @(negedge clk);
    rsp_done = 1'b0;
    rd(12'h45C, v); check("R5 idle done ignored status", v, exp_status(req_b, 1'b0));
    rd(12'h458, v); check("R10 result word held", v, arg_m[0] + 32'd1);
    rd(12'h43C, v); check("R5 idle done request", v, 0);

    check("R3 total launches", 32'(starts), 32'd2);
    check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule